// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This block is the arithmetic heart of a memory-side atomic engine. Each request carries the current contents of the addressed memory word, the data the requester sent, a form, an operation and an operand size. One clock later the block presents the value to write back, a write enable that tells the memory whether to commit it, and the original value to hand back to the requester. The block has no handshake or address logic, and it does not hold the memory array. It sits between the read and write ports of a store that the surrounding logic already controls.

There are four forms. A store form updates memory and returns nothing. A load form updates memory and also returns the old value. A swap form overwrites memory with the sent value. A compare form writes its swap half only when memory matches its compare half. The store and load forms use one of eight operations: add, bit-clear, bit-set, exclusive-or, and signed or unsigned maximum and minimum. All byte lanes are little-endian. A lane outside the active operand size is never modified.

Top module: `amo_unit`

## Requirements
- R1: Operation code 0 (add) writes the sum of the memory operand and the sent operand, wrapped modulo 2^(8×bytes), with no carry into higher lanes.
- R2: Operation code 1 clears each memory bit whose sent bit is 1. Code 3 sets each memory bit whose sent bit is 1. Code 2 writes the bitwise XOR.
- R3: Codes 4 (signed max) and 5 (signed min) compare the operands as two's-complement values whose sign bit is the top bit of the active size.
- R4: Codes 6 (unsigned max) and 7 (unsigned min) compare the operands as unsigned values of the active size.
- R5: Form field 0 is store and form 1 is load. Both always write. Load raises ret_valid_o with the original operand, and store leaves ret_valid_o low.
- R6: Form 2 (swap) always writes the sent operand and returns the prior memory operand.
- R7: Form 3 (compare) has an outbound size of 2^size_i bytes, with size_i from 1 to 5. The compare value occupies the low half of the outbound bytes of send_data_i and the swap value occupies the next half. The swap value is written only when the memory's low half-size bytes equal the compare value. The original half-size value is always returned, and no success flag exists.
- R8: size_i gives log2 of the outbound byte count. Write-data bytes above the active operand size equal the memory input. Returned bytes above the returned size are zero.
- R9: err_o is raised, and neither wr_en_o nor ret_valid_o, when the request is illegal. An illegal request is a store, load or swap with size_i above 3, a store or load with an operation code of 8 or more, or a compare with size_i of 0 or above 5.
- R10: All outputs are registered and appear in the cycle after req_valid_i is sampled. done_o pulses for each request, and every flag is low after reset and in idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| form_i | input | 2 | 0 store, 1 load, 2 swap, 3 compare |
| op_i | input | 4 | Operation code 0..7 for store/load |
| size_i | input | 3 | log2 of outbound byte count |
| mem_data_i | input | 128 | Current memory word |
| send_data_i | input | 256 | Data sent by the requester |
| done_o | output | 1 | Result valid pulse |
| wr_en_o | output | 1 | Commit wr_data_o to memory |
| wr_data_o | output | 128 | New memory word |
| ret_valid_o | output | 1 | ret_data_o carries a returned value |
| ret_data_o | output | 128 | Original value returned, zero-extended |
| err_o | output | 1 | Illegal form/operation/size |

## Verification
The bench aims at the sign boundary of each operand size. A signed comparator that takes its sign from bit 63 would rank 0x80 above 0x01 at one byte. It also aims at an add of 0xFF plus 1 in a one-byte lane, where a carry that leaks would disturb byte 1. For compare-and-swap, the directed and random cases are forced to match about half of the time, so that a design that always or never writes would be caught. This is done at every outbound size, including 32 bytes, where a wrong half offset would write the compare value. Illegal sizes and operation codes are mixed into the random stream, so any write or return on an erroneous request shows up.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam int N_OPS = 8;

  typedef enum logic [1:0] {
    FORM_STORE = 2'd0,
    FORM_LOAD  = 2'd1,
    FORM_SWAP  = 2'd2,
    FORM_CMP   = 2'd3
  } amo_form_e;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_CLR  = 4'd1,
    OP_EOR  = 4'd2,
    OP_SET  = 4'd3,
    OP_SMAX = 4'd4,
    OP_SMIN = 4'd5,
    OP_UMAX = 4'd6,
    OP_UMIN = 4'd7
  } amo_op_e;
endpackage

// File: rtl/amo_byte_mask.sv
module amo_byte_mask #(
  parameter int NB  = 16,
  parameter int SZW = 3
) (
  input  logic [SZW-1:0]  size_i,
  output logic [NB*8-1:0] mask_o
);
  localparam int CW = (1 << SZW) + 1;

  logic [CW-1:0] nbytes;
  assign nbytes = CW'(1) << size_i;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign mask_o[g*8 +: 8] = {8{CW'(g) < nbytes}};
  end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic [AW-1:0] mem_i,
  input  logic [AW-1:0] arg_i,
  input  amo_op_e       op_i,
  input  logic [2:0]    size_i,
  output logic [AW-1:0] res_o
);
  localparam int SHW = $clog2(AW) + 1;

  logic [AW-1:0]        m, a, b, res;
  logic [10:0]          act_bits;
  logic [SHW-1:0]       sh;
  logic signed [AW-1:0] sa, sb;
  logic                 s_gt, u_gt;

  amo_byte_mask #(.NB(AW/8), .SZW(3)) u_mask (.size_i(size_i), .mask_o(m));

  assign act_bits = 11'd8 << size_i;
  assign sh       = SHW'(AW) - act_bits[SHW-1:0];
  assign a        = mem_i & m;
  assign b        = arg_i & m;
  // shift the active sign bit to the top, then back arithmetically
  assign sa       = $signed(mem_i << sh) >>> sh;
  assign sb       = $signed(arg_i << sh) >>> sh;
  assign s_gt     = sa > sb;
  assign u_gt     = a > b;

  always_comb begin
    case (op_i)
      OP_ADD:  res = a + b;
      OP_CLR:  res = a & ~b;
      OP_EOR:  res = a ^ b;
      OP_SET:  res = a | b;
      OP_SMAX: res = s_gt ? a : b;
      OP_SMIN: res = s_gt ? b : a;
      OP_UMAX: res = u_gt ? a : b;
      OP_UMIN: res = u_gt ? b : a;
      default: res = a;
    endcase
  end

  assign res_o = res & m;
endmodule

// File: rtl/amo_cas.sv
module amo_cas #(
  parameter int WW = 128
) (
  input  logic [WW-1:0]   mem_i,
  input  logic [2*WW-1:0] send_i,
  input  logic [2:0]      size_i,
  output logic            match_o,
  output logic [WW-1:0]   hmask_o,
  output logic [WW-1:0]   new_o
);
  logic [2:0]      hsize;
  logic [10:0]     hbits;
  logic [2*WW-1:0] swp_all;
  logic [WW-1:0]   cmp, swp;

  assign hsize = size_i - 3'd1;

  amo_byte_mask #(.NB(WW/8), .SZW(3)) u_hmask (.size_i(hsize), .mask_o(hmask_o));

  assign hbits   = 11'd8 << hsize;
  assign swp_all = send_i >> hbits;
  assign swp     = swp_all[WW-1:0];
  assign cmp     = send_i[WW-1:0];
  assign match_o = ((mem_i ^ cmp) & hmask_o) == '0;
  assign new_o   = match_o ? ((mem_i & ~hmask_o) | (swp & hmask_o)) : mem_i;
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int WORD_BYTES    = 16,
  parameter int AMO_MAX_BYTES = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  input  logic [1:0]              form_i,
  input  logic [3:0]              op_i,
  input  logic [2:0]              size_i,
  input  logic [WORD_BYTES*8-1:0] mem_data_i,
  input  logic [WORD_BYTES*16-1:0] send_data_i,
  output logic                    done_o,
  output logic                    wr_en_o,
  output logic [WORD_BYTES*8-1:0] wr_data_o,
  output logic                    ret_valid_o,
  output logic [WORD_BYTES*8-1:0] ret_data_o,
  output logic                    err_o
);
  localparam int WW         = WORD_BYTES * 8;
  localparam int AW         = AMO_MAX_BYTES * 8;
  localparam int AMO_MAX_SZ = $clog2(AMO_MAX_BYTES);
  localparam int CMP_MAX_SZ = $clog2(2 * WORD_BYTES);

  logic [WW-1:0] m_w, hm, cas_new, alu_w;
  logic [AW-1:0] alu_res;
  logic          cas_match, amo_size_ok, op_ok;
  logic          n_wr, n_rv, n_err;
  logic [WW-1:0] n_wd, n_rd;

  amo_byte_mask #(.NB(WORD_BYTES), .SZW(3)) u_mask (.size_i(size_i), .mask_o(m_w));

  amo_alu #(.AW(AW)) u_alu (
    .mem_i  (mem_data_i[AW-1:0]),
    .arg_i  (send_data_i[AW-1:0]),
    .op_i   (amo_op_e'(op_i)),
    .size_i (size_i),
    .res_o  (alu_res)
  );

  amo_cas #(.WW(WW)) u_cas (
    .mem_i   (mem_data_i),
    .send_i  (send_data_i),
    .size_i  (size_i),
    .match_o (cas_match),
    .hmask_o (hm),
    .new_o   (cas_new)
  );

  assign alu_w       = WW'(alu_res);
  assign amo_size_ok = size_i <= 3'(AMO_MAX_SZ);
  assign op_ok       = op_i < 4'(N_OPS);

  always_comb begin
    n_wr  = 1'b0;
    n_rv  = 1'b0;
    n_err = 1'b0;
    n_wd  = mem_data_i;
    n_rd  = '0;
    case (form_i)
      FORM_STORE, FORM_LOAD: begin
        n_err = !(amo_size_ok && op_ok);
        if (!n_err) begin
          n_wr = 1'b1;
          n_wd = (mem_data_i & ~m_w) | (alu_w & m_w);
          if (form_i == FORM_LOAD) begin
            n_rv = 1'b1;
            n_rd = mem_data_i & m_w;
          end
        end
      end
      FORM_SWAP: begin
        n_err = !amo_size_ok;
        if (!n_err) begin
          n_wr = 1'b1;
          n_rv = 1'b1;
          n_wd = (mem_data_i & ~m_w) | (send_data_i[WW-1:0] & m_w);
          n_rd = mem_data_i & m_w;
        end
      end
      default: begin
        n_err = (size_i == 3'd0) || (size_i > 3'(CMP_MAX_SZ));
        if (!n_err) begin
          n_wr = cas_match;
          n_rv = 1'b1;
          n_wd = cas_new;
          n_rd = mem_data_i & hm;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      wr_en_o     <= 1'b0;
      ret_valid_o <= 1'b0;
      err_o       <= 1'b0;
      wr_data_o   <= '0;
      ret_data_o  <= '0;
    end else begin
      done_o      <= req_valid_i;
      wr_en_o     <= req_valid_i & n_wr;
      ret_valid_o <= req_valid_i & n_rv;
      err_o       <= req_valid_i & n_err;
      if (req_valid_i) begin
        wr_data_o  <= n_wd;
        ret_data_o <= n_rd;
      end
    end
  end
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk #(
  parameter int WORD_BYTES = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     req_valid_i,
  input logic [1:0]               form_i,
  input logic [3:0]               op_i,
  input logic [2:0]               size_i,
  input logic [WORD_BYTES*8-1:0]  mem_data_i,
  input logic [WORD_BYTES*16-1:0] send_data_i,
  input logic                     done_o,
  input logic                     wr_en_o,
  input logic [WORD_BYTES*8-1:0]  wr_data_o,
  input logic                     ret_valid_o,
  input logic [WORD_BYTES*8-1:0]  ret_data_o,
  input logic                     err_o
);
  localparam int WW = WORD_BYTES * 8;

  p_done_follows_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> done_o);
  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !done_o && !wr_en_o && !ret_valid_o && !err_o);
  p_err_blocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !wr_en_o && !ret_valid_o);
  p_store_no_ret_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && form_i == 2'd0) |=> !ret_valid_o);
  p_swap_prior_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && form_i == 2'd2 && size_i == 3'd3)
      |=> wr_en_o && ret_data_o[63:0] == $past(mem_data_i[63:0]));
  p_cas_miss_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && form_i == 2'd3 && size_i == 3'd1 && mem_data_i[7:0] != send_data_i[7:0])
      |=> !wr_en_o && ret_valid_o);
  p_upper_kept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && form_i[1] == 1'b0 && size_i == 3'd0 && op_i < 4'd8)
      |=> wr_data_o[WW-1:8] == $past(mem_data_i[WW-1:8]));
endmodule

bind amo_unit amo_unit_chk #(.WORD_BYTES(WORD_BYTES)) u_chk (.*);

// File: tb/amo_unit_test.sv
`timescale 1ns/1ps
module amo_unit_test;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_valid_i = 1'b0;
  logic [1:0]   form_i = '0;
  logic [3:0]   op_i = '0;
  logic [2:0]   size_i = '0;
  logic [127:0] mem_data_i = '0;
  logic [255:0] send_data_i = '0;
  logic         done_o, wr_en_o, ret_valid_o, err_o;
  logic [127:0] wr_data_o, ret_data_o;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #2.5 clk_i = ~clk_i;

  amo_unit uut (.*);

  function automatic logic [63:0] sext(input logic [63:0] v, input int n);
    logic [63:0] r;
    r = v;
    if (n < 8 && v[8*n-1]) for (int i = 8*n; i < 64; i++) r[i] = 1'b1;
    return r;
  endfunction

  function automatic void model(
    input logic [1:0] f, input logic [3:0] op, input logic [2:0] sz,
    input logic [127:0] mem, input logic [255:0] snd,
    output bit wr, output logic [127:0] wd, output bit rv,
    output logic [127:0] rd, output bit er, output string tag);
    int n;
    logic [63:0] m64, a, d, r;
    bit eq;
    n = 1 << sz;
    wr = 0; rv = 0; er = 0; wd = mem; rd = '0;
    tag = "R9";
    if (f == 2'd3) begin
      if (sz == 0 || sz > 5) begin er = 1; return; end
      tag = "R7";
      eq = 1;
      for (int b = 0; b < n/2; b++) begin
        if (mem[8*b +: 8] != snd[8*b +: 8]) eq = 0;
        rd[8*b +: 8] = mem[8*b +: 8];
      end
      rv = 1; wr = eq;
      if (eq) for (int b = 0; b < n/2; b++) wd[8*b +: 8] = snd[8*(b + n/2) +: 8];
      return;
    end
    if (sz > 3 || (f != 2'd2 && op > 7)) begin er = 1; return; end
    m64 = (n == 8) ? '1 : ((64'd1 << (8*n)) - 64'd1);
    a = mem[63:0] & m64;
    d = snd[63:0] & m64;
    if (f == 2'd2) begin
      tag = "R6"; r = d;
    end else begin
      case (op)
        4'd0: begin r = a + d; tag = "R1"; end
        4'd1: begin r = a & ~d; tag = "R2"; end
        4'd2: begin r = a ^ d; tag = "R2"; end
        4'd3: begin r = a | d; tag = "R2"; end
        4'd4: begin r = ($signed(sext(a, n)) > $signed(sext(d, n))) ? a : d; tag = "R3"; end
        4'd5: begin r = ($signed(sext(a, n)) < $signed(sext(d, n))) ? a : d; tag = "R3"; end
        4'd6: begin r = (a > d) ? a : d; tag = "R4"; end
        default: begin r = (a < d) ? a : d; tag = "R4"; end
      endcase
      if (f == 2'd0) tag = {tag, "/R5"};
    end
    wr = 1;
    wd[63:0] = (mem[63:0] & ~m64) | (r & m64);
    if (f != 2'd0) begin rv = 1; rd[63:0] = a; end
  endfunction

  task automatic check(input string req, input logic [259:0] act, input logic [259:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive at negedge, sample at following negedge
  task automatic run(input logic [1:0] f, input logic [3:0] op, input logic [2:0] sz,
                     input logic [127:0] mem, input logic [255:0] snd);
    bit wr, rv, er;
    logic [127:0] wd, rd;
    string tag;
    model(f, op, sz, mem, snd, wr, wd, rv, rd, er, tag);
    form_i = f; op_i = op; size_i = sz; mem_data_i = mem; send_data_i = snd;
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check({tag, "/R8/R10"}, {done_o, wr_en_o, ret_valid_o, err_o, wr_data_o, ret_data_o},
          {1'b1, wr, rv, er, wd, rd});
  endtask

  function automatic logic [127:0] r128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(5.0 * 100000);
    if (!ended) begin
      bad++; total++;
      $display("FAIL watchdog R10 act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] mem;
    logic [255:0] snd;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R10 reset state
    check("R10 reset", {done_o, wr_en_o, ret_valid_o, err_o, wr_data_o, ret_data_o}, '0);

    // R1 wrap in one byte, upper bytes kept
    mem = 128'h0123_4567_89ab_cdef_0011_2233_4455_66ff;
    run(2'd1, 4'd0, 3'd0, mem, 256'h01);
    // R1 wrap at 8 bytes
    run(2'd0, 4'd0, 3'd3, {64'h5555, 64'hffff_ffff_ffff_ffff}, 256'h2);
    // R3 sign at byte boundary: 0x80 is negative
    run(2'd1, 4'd4, 3'd0, 128'h80, 256'h01);
    run(2'd1, 4'd5, 3'd1, 128'h8000, 256'h7fff);
    // R4 unsigned
    run(2'd1, 4'd6, 3'd0, 128'h80, 256'h01);
    run(2'd1, 4'd7, 3'd2, 128'hffff_ffff, 256'h1);
    // R2
    run(2'd1, 4'd1, 3'd1, 128'hffff, 256'h0f0f);
    run(2'd1, 4'd3, 3'd1, 128'h0000, 256'h0f0f);
    run(2'd0, 4'd2, 3'd2, 128'haaaa_aaaa, 256'hffff_0000);
    // R6 swap
    run(2'd2, 4'd0, 3'd3, r128(), {128'h0, r128()});
    // R7 compare hit/miss at 32 bytes and at 2 bytes
    mem = r128();
    run(2'd3, 4'd0, 3'd5, mem, {r128(), mem});
    run(2'd3, 4'd0, 3'd5, mem, {r128(), ~mem});
    run(2'd3, 4'd0, 3'd1, 128'h12, 256'h3412);
    run(2'd3, 4'd0, 3'd1, 128'h13, 256'h3412);
    // R9 illegal combos
    run(2'd0, 4'd9, 3'd0, r128(), 256'h1);
    run(2'd3, 4'd0, 3'd0, r128(), 256'h1);
    run(2'd2, 4'd0, 3'd4, r128(), 256'h1);
    run(2'd3, 4'd0, 3'd6, r128(), 256'h1);
    // R10 idle cycle is quiet
    @(negedge clk_i);
    check("R10 idle", {done_o, wr_en_o, ret_valid_o, err_o}, 4'b0);

    for (int i = 0; i < 400; i++) begin
      logic [1:0] f;
      logic [3:0] op;
      logic [2:0] sz;
      f   = 2'($urandom);
      op  = ($urandom_range(0, 9) == 0) ? 4'($urandom) : 4'($urandom_range(0, 7));
      sz  = ($urandom_range(0, 7) == 0) ? 3'($urandom) :
            (f == 2'd3) ? 3'($urandom_range(1, 5)) : 3'($urandom_range(0, 3));
      mem = r128();
      snd = {r128(), r128()};
      if (f == 2'd3 && $urandom_range(0, 1) == 1) snd[127:0] = mem;
      if ($urandom_range(0, 3) == 0) snd[7] = ~mem[7];
      run(f, op, sz, mem, snd);
    end

    ended = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule